// File: doc/BRIEF.md
# Reversing Converter Bank Selector

This block chooses which of two anti-parallel thyristor converter banks may be fired in a reversible DC drive. One bank drives the motor forward and the other drives it in reverse. It reads the sign of the torque demand from the speed regulator, together with a raw zero-current flag from the armature circuit. It drives one enable bit per bank, and those bits gate that bank's firing pulses downstream.

The two enable bits form the block's status register. A bit holds 1 while its bank is released and 0 while its bank is locked. At most one bit is ever 1. When the demand changes sign, the active bank is locked at once. The block then waits until the zero-current flag has been stable for `ZC_STABLE` cycles. After that it waits a further `DEAD_CYC` cycles of dead-time before it releases the opposite bank. If current reappears during the dead-time, the zero-current qualification starts again.

All pins are plain level signals sampled on the rising clock edge. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `bank_selector`

## Requirements
- R1: While reset is asserted and after it is released, both enables are 0 and `mode` is 2'b00. This holds until the first release described in R2.
- R2: While both banks are locked outside a changeover, the first release happens at the first clock edge where `dmd_valid`=1 and the zero-current flag is qualified. The forward bank is released if `dmd_neg`=0, and the reverse bank if `dmd_neg`=1. Without a valid demand, both banks stay locked.
- R3: `fwd_en` and `rev_en` are never both 1.
- R4: If `dmd_valid`=1 and the sign of `dmd_neg` calls for the bank that is not active, the active bank's enable drops at the next clock edge.
- R5: After a bank has been locked by R4, the opposite bank is released exactly `DEAD_CYC` edges after the first edge that sees the qualified zero flag. With the flag already qualified, this is `DEAD_CYC`+2 edges after the demand changes sign.
- R6: The zero flag counts as qualified only after `izero_raw` has been 1 at `ZC_STABLE` consecutive edges. A pulse of 1 that is shorter than this releases nothing.
- R7: If the qualified zero flag is lost during the dead-time, the dead-time is abandoned. A new qualification of `ZC_STABLE` cycles, followed by a full `DEAD_CYC` dead-time, is then required.
- R8: While a bank is active, `dmd_valid`=0, or a demand whose sign matches the active bank, leaves that bank released.
- R9: Once a changeover has begun, it completes to the bank chosen at its start, even if the demand sign reverts.
- R10: `mode` is 2'b01 when the forward bank is released, 2'b10 when the reverse bank is released, and 2'b00 when neither is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dmd_valid | input | 1 | Torque demand is nonzero and its sign is meaningful |
| dmd_neg | input | 1 | Demand sign: 1 = reverse, 0 = forward |
| izero_raw | input | 1 | Unfiltered armature zero-current detect |
| fwd_en | output | 1 | Forward bank release (status bit) |
| rev_en | output | 1 | Reverse bank release (status bit) |
| mode | output | 2 | {rev_en, fwd_en}: 01 forward, 10 reverse, 00 none |

## Verification
The bench sweeps every zero-flag glitch length shorter than the qualification window. A filter that accepted a short pulse would release the opposite bank early, while current may still be flowing. Each changeover's release is sampled one edge before and one edge after the predicted cycle, which catches an off-by-one dead-time in either direction. The bench drops the zero flag in the middle of the dead-time. A design that merely paused or ignored the loss would release cycles earlier than a full requalification allows. It also reverts the demand during a changeover, and it restarts from reset in the reverse direction, where a design with a forward bias at startup would pick the wrong bank.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FWD  = 3'd1,
    ST_REV  = 3'd2,
    ST_WAIT = 3'd3,
    ST_DEAD = 3'd4
  } sel_st_t;
endpackage

// File: rtl/zc_qualify.sv
module zc_qualify #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic qual
);
  localparam int CW = $clog2(STABLE + 1);
  localparam logic [CW-1:0] FULL = CW'(STABLE);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= '0;
    else if (!raw)     run_q <= '0;
    else if (run_q != FULL) run_q <= run_q + 1'b1;
  end

  assign qual = (run_q == FULL);

  // a low sample always withdraws qualification
  p_filter_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> !qual);
endmodule

// File: rtl/dead_timer.sv
module dead_timer #(
  parameter int DEAD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (DEAD > 1) ? $clog2(DEAD) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEAD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  // timer restarts from zero every time it is started
  p_fresh_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/bank_selector.sv
module bank_selector
  import bank_sel_pkg::*;
#(
  parameter int ZC_STABLE = 4,
  parameter int DEAD_CYC  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dmd_valid,
  input  logic       dmd_neg,
  input  logic       izero_raw,
  output logic       fwd_en,
  output logic       rev_en,
  output logic [1:0] mode
);
  sel_st_t st_q, st_d;
  logic    tgt_rev_q, tgt_rev_d;
  logic    zq, dt_done;
  logic [1:0] stat_q;

  zc_qualify #(.STABLE(ZC_STABLE)) u_zq (
    .clk(clk), .rst_n(rst_n), .raw(izero_raw), .qual(zq)
  );

  dead_timer #(.DEAD(DEAD_CYC)) u_dt (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_DEAD), .done(dt_done)
  );

  always_comb begin
    st_d      = st_q;
    tgt_rev_d = tgt_rev_q;
    unique case (st_q)
      ST_IDLE: if (dmd_valid && zq) st_d = dmd_neg ? ST_REV : ST_FWD;
      ST_FWD:  if (dmd_valid && dmd_neg) begin
                 st_d = ST_WAIT; tgt_rev_d = 1'b1;
               end
      ST_REV:  if (dmd_valid && !dmd_neg) begin
                 st_d = ST_WAIT; tgt_rev_d = 1'b0;
               end
      ST_WAIT: if (zq) st_d = ST_DEAD;
      ST_DEAD: if (!zq) st_d = ST_WAIT;
               else if (dt_done) st_d = tgt_rev_q ? ST_REV : ST_FWD;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      tgt_rev_q <= 1'b0;
      stat_q    <= 2'b00;
    end else begin
      st_q      <= st_d;
      tgt_rev_q <= tgt_rev_d;
      stat_q    <= {st_d == ST_REV, st_d == ST_FWD};
    end
  end

  assign fwd_en = stat_q[0];
  assign rev_en = stat_q[1];
  assign mode   = stat_q;

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_en && rev_en));

  p_zero_gate_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_en) |-> $past(zq));

  p_zero_gate_rev_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rev_en) |-> $past(zq));

  p_lock_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && dmd_valid && dmd_neg) |=> !fwd_en);

  p_dead_before_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |=> !(fwd_en || rev_en));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_en && !(dmd_valid && !dmd_neg)) |=> rev_en);
endmodule

// File: tb/tb_bank_selector.sv
module tb_bank_selector;
  localparam int ZC = 3;
  localparam int DT = 4;

  logic clk = 1'b0;
  logic rst_n, dmd_valid, dmd_neg, izero_raw;
  logic fwd_en, rev_en;
  logic [1:0] mode;
  int total = 0;
  int bad = 0;
  bit fin = 1'b0;

  always #5 clk = ~clk;

  bank_selector #(.ZC_STABLE(ZC), .DEAD_CYC(DT)) dut (
    .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_neg(dmd_neg),
    .izero_raw(izero_raw), .fwd_en(fwd_en), .rev_en(rev_en), .mode(mode)
  );

  task automatic check(input string tag, input logic [1:0] exp);
    total++;
    if (mode !== exp || {rev_en, fwd_en} !== exp) begin
      bad++;
      $display("FAIL %s: got mode=%b en=%b%b expected %b",
               tag, mode, rev_en, fwd_en, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      total++;
      if (fwd_en && rev_en) begin
        bad++;
        $display("FAIL R3: got both enabled expected at most one");
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dmd_valid = 1'b0; dmd_neg = 1'b0; izero_raw = 1'b0;
    tick(3);
    check("R1 in reset", 2'b00);
    rst_n = 1'b1;
    tick(1);
    check("R1 after reset", 2'b00);

    izero_raw = 1'b1;
    tick(8);
    check("R2 no demand stays locked", 2'b00);
    dmd_valid = 1'b1;
    tick(1);
    check("R2 first release forward", 2'b01);
    check("R10 forward code", 2'b01);

    tick(5);
    check("R8 same sign holds", 2'b01);
    dmd_valid = 1'b0; dmd_neg = 1'b1;
    tick(5);
    check("R8 invalid demand holds", 2'b01);

    for (int g = 1; g < ZC; g++) begin
      izero_raw = 1'b0; dmd_valid = 1'b1; dmd_neg = 1'b1;
      tick(1);
      check("R4 lock on reversal", 2'b00);
      tick(2);
      izero_raw = 1'b1;
      tick(g);
      izero_raw = 1'b0;
      tick(ZC + DT + 2);
      check("R6 short zero pulse ignored", 2'b00);
      izero_raw = 1'b1;
      tick(ZC + DT);
      check("R5 one edge before release", 2'b00);
      tick(1);
      check("R5 reverse released", 2'b10);
      check("R10 reverse code", 2'b10);
      dmd_neg = 1'b0;
      tick(DT + 1);
      check("R5 back, one edge early", 2'b00);
      tick(1);
      check("R5 forward released", 2'b01);
    end

    dmd_neg = 1'b1;
    tick(2);
    izero_raw = 1'b0;
    tick(1);
    izero_raw = 1'b1;
    tick(3);
    check("R7 no release at normal time", 2'b00);
    tick(ZC + DT - 3);
    check("R7 one edge before late release", 2'b00);
    tick(1);
    check("R7 released after requalify", 2'b10);

    dmd_neg = 1'b0;
    tick(1);
    check("R4 lock reverse", 2'b00);
    dmd_neg = 1'b1;
    tick(DT);
    check("R9 still waiting", 2'b00);
    tick(1);
    check("R9 committed bank released", 2'b01);

    rst_n = 1'b0; izero_raw = 1'b0; dmd_valid = 1'b0; dmd_neg = 1'b0;
    tick(2);
    check("R1 second reset", 2'b00);
    rst_n = 1'b1; dmd_valid = 1'b1; dmd_neg = 1'b1; izero_raw = 1'b1;
    tick(ZC);
    check("R6 startup waits qualification", 2'b00);
    tick(1);
    check("R2 first release reverse", 2'b10);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule